// File: doc/BRIEF.md
# Legacy keyboard and border I/O port

This block sits on the processor's I/O bus inside a video/IO controller and serves the legacy port. A write sets the three-bit border colour index and the two cassette/speaker output bits, ear and mic. A read returns the state of the keyboard rows that the upper address byte selects, merged into a single five-bit field, with the ear input level and two fixed ones.

Both the key matrix and the row selects are active low. A row is selected by clearing its address bit. Several rows may be selected at once, and a key held in any selected row pulls its column to 0. The controller can lock itself into classic mode, and this block takes that lock as an input. While the lock is set, bits 7..5 of the address are not decoded, so every access with A0 low reaches this port.

Top module: `kbd_border_port`

## Requirements
- R1: The port is selected when addr_i[0] = 0 and addr_i[7:5] = 3'b111. While the lock is clear, a write to any other address leaves border_o, ear_o and mic_o unchanged, and a read of any other address returns 8'hFF.
- R2: A selected write is captured on the rising clock edge at which wr_i is high. After that edge, border_o = data_i[2:0], ear_o = data_i[3] and mic_o = data_i[4].
- R3: Write data bits 7..5 have no effect on any output.
- R4: A selected read returns bit 7 = 1, bit 5 = 1 and bit 6 = ear_i, all combinationally while rd_i is high.
- R5: Row r (0..7) is selected when addr_i[8+r] = 0. Its five keys are keys_ni[5r+4:5r], where 0 means pressed. Read bits 4..0 are the bitwise AND of all selected rows, and they are 5'b11111 when no row is selected.
- R6: While rd_i is low, data_o is 8'hFF.
- R7: While classic_lock_i is 1, addr_i[7:5] is ignored, and any access with addr_i[0] = 0 acts on the port.
- R8: While rst_ni is low, border_o, ear_o and mic_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O address; the upper byte selects key rows |
| rd_i | input | 1 | I/O read strobe |
| wr_i | input | 1 | I/O write strobe |
| data_i | input | 8 | Write data |
| classic_lock_i | input | 1 | Classic-mode lock, widens the decode |
| keys_ni | input | 40 | Key matrix, 8 rows of 5 keys, active low |
| ear_i | input | 1 | Ear input level |
| data_o | output | 8 | Read data, 8'hFF when not reading the port |
| border_o | output | 3 | Border colour index |
| ear_o | output | 1 | Ear output bit |
| mic_o | output | 1 | Mic output bit |

## Verification
A read and a write to the port can be asserted in the same cycle, and the bench provokes this with random strobes at random addresses. In such a cycle the read must show the ear input and the current key state, never the ear value being written. The new border, ear and mic values must appear only after the clock edge. The bench judges each such cycle against two independent models: a read-format function, and an output register model that it updates only when a write hits the port.

// File: rtl/kbd_port_pkg.sv
package kbd_port_pkg;
  localparam int unsigned ROWS       = 8;
  localparam int unsigned KEYS       = 5;
  localparam int unsigned BORDER_W   = 3;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned ROW_SEL_LO = 8;

  typedef struct packed {
    logic                mic;
    logic                ear;
    logic [BORDER_W-1:0] border;
  } port_out_t;
endpackage

// File: rtl/kbd_port_decode.sv
module kbd_port_decode (
  input  logic       a0_i,
  input  logic [2:0] a_hi_i,
  input  logic       lock_i,
  input  logic       rd_i,
  input  logic       wr_i,
  output logic       rd_hit_o,
  output logic       wr_hit_o
);
  logic hit;
  // lock widens decode to A0 only
  assign hit      = ~a0_i & (lock_i | (&a_hi_i));
  assign rd_hit_o = hit & rd_i;
  assign wr_hit_o = hit & wr_i;
endmodule

// File: rtl/kbd_row_merge.sv
module kbd_row_merge #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned KEYS = 5
) (
  input  logic [ROWS-1:0]      row_sel_ni,
  input  logic [ROWS*KEYS-1:0] keys_ni,
  output logic [KEYS-1:0]      cols_no
);
  logic [KEYS-1:0] masked [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign masked[r] = row_sel_ni[r] ? {KEYS{1'b1}} : keys_ni[r*KEYS +: KEYS];
  end

  always_comb begin
    cols_no = {KEYS{1'b1}};
    for (int r = 0; r < ROWS; r++) cols_no &= masked[r];
  end
endmodule

// File: rtl/kbd_port_regs.sv
module kbd_port_regs
  import kbd_port_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_hit_i,
  input  port_out_t wdata_i,
  output port_out_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (wr_hit_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/kbd_border_port.sv
module kbd_border_port
  import kbd_port_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [7:0]           data_i,
  input  logic                 classic_lock_i,
  input  logic [ROWS*KEYS-1:0] keys_ni,
  input  logic                 ear_i,
  output logic [7:0]           data_o,
  output logic [BORDER_W-1:0]  border_o,
  output logic                 ear_o,
  output logic                 mic_o
);
  localparam int unsigned ROW_SEL_HI = ROW_SEL_LO + ROWS - 1;

  logic            rd_hit, wr_hit;
  logic [KEYS-1:0] cols_n;
  port_out_t       wdata, q;
  logic            unused_bits;

  assign unused_bits = ^{addr_i[4:1], data_i[7:5]};

  kbd_port_decode u_dec (
    .a0_i    (addr_i[0]),
    .a_hi_i  (addr_i[7:5]),
    .lock_i  (classic_lock_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .rd_hit_o(rd_hit),
    .wr_hit_o(wr_hit)
  );

  kbd_row_merge #(.ROWS(ROWS), .KEYS(KEYS)) u_merge (
    .row_sel_ni(addr_i[ROW_SEL_HI:ROW_SEL_LO]),
    .keys_ni   (keys_ni),
    .cols_no   (cols_n)
  );

  assign wdata = '{mic: data_i[4], ear: data_i[3], border: data_i[2:0]};

  kbd_port_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_hit_i(wr_hit),
    .wdata_i (wdata),
    .q_o     (q)
  );

  assign data_o   = rd_hit ? {1'b1, ear_i, 1'b1, cols_n} : 8'hFF;
  assign border_o = q.border;
  assign ear_o    = q.ear;
  assign mic_o    = q.mic;
endmodule

// File: rtl/kbd_border_port_chk.sv
module kbd_border_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        rd_i,
  input logic        wr_i,
  input logic [7:0]  data_i,
  input logic        classic_lock_i,
  input logic        ear_i,
  input logic [7:0]  data_o,
  input logic [2:0]  border_o,
  input logic        ear_o,
  input logic        mic_o
);
  logic sel;
  assign sel = !addr_i[0] && (classic_lock_i || addr_i[7:5] == 3'b111);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r8: assert (border_o == 3'd0 && !ear_o && !mic_o);
    end
  end

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel) |=> $stable({border_o, ear_o, mic_o}));

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel) |=> ({mic_o, ear_o, border_o} == $past(data_i[4:0])));

  p_read_fmt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel) |-> (data_o[7] && data_o[5] && data_o[6] == ear_i));

  p_idle_ff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> data_o == 8'hFF);

  p_lock_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (classic_lock_i && wr_i && !addr_i[0]) |=> mic_o == $past(data_i[4]));
endmodule

bind kbd_border_port kbd_border_port_chk u_chk (
  .clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .data_i, .classic_lock_i,
  .ear_i, .data_o, .border_o, .ear_o, .mic_o
);

// File: tb/kbd_border_port_test.sv
module kbd_border_port_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [15:0] addr_i = 16'hFFFF;
  logic        rd_i = 0, wr_i = 0;
  logic [7:0]  data_i = 0;
  logic        classic_lock_i = 0;
  logic [39:0] keys_ni = '1;
  logic        ear_i = 0;
  logic [7:0]  data_o;
  logic [2:0]  border_o;
  logic        ear_o, mic_o;

  int checks = 0, errors = 0;
  logic [4:0] m_out = 0;  // {mic, ear, border}
  bit done = 0;

  always #4 clk_i = ~clk_i;

  kbd_border_port uut (.*);

  function automatic bit hit(logic [15:0] a, logic lk);
    return !a[0] && (lk || a[7:5] == 3'b111);
  endfunction

  function automatic logic [7:0] exp_rd(logic [15:0] a, logic lk, logic [39:0] k, logic e);
    logic [4:0] c = 5'h1F;
    if (!hit(a, lk)) return 8'hFF;
    for (int r = 0; r < 8; r++) if (!a[8+r]) c &= k[r*5 +: 5];
    return {1'b1, e, 1'b1, c};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(string req);
    chk(req, {27'd0, mic_o, ear_o, border_o}, {27'd0, m_out});
  endtask

  // one bus cycle; rd and wr may both be high
  task automatic cycle(logic [15:0] a, logic r, logic w, logic [7:0] d, string req);
    @(negedge clk_i);
    addr_i = a; rd_i = r; wr_i = w; data_i = d;
    #1;
    chk(req, {24'd0, data_o}, {24'd0, r ? exp_rd(a, classic_lock_i, keys_ni, ear_i) : 8'hFF});
    @(negedge clk_i);
    if (w && hit(a, classic_lock_i)) m_out = d[4:0];
    rd_i = 0; wr_i = 0;
    #1;
    chk_out(req);
    chk({req, "/R6"}, {24'd0, data_o}, 32'hFF);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R8 reset state
    #13;
    chk_out("R8");
    rst_ni = 1;
    // R2 write, R3 high bits ignored
    cycle(16'h00FE, 0, 1, 8'h1D, "R2");
    cycle(16'h00FE, 0, 1, 8'hE2, "R3");
    // R1 non-matching address ignored
    cycle(16'h007E, 0, 1, 8'h1F, "R1");
    cycle(16'h00FF, 1, 1, 8'h1F, "R1");
    // R5 single, multiple, none selected
    keys_ni = '1; keys_ni[2] = 0; keys_ni[5*3+4] = 0; keys_ni[5*7+0] = 0;
    ear_i = 1;
    cycle(16'hFEFE, 1, 0, 0, "R5");
    cycle(16'hF6FE, 1, 0, 0, "R5");
    cycle(16'h76FE, 1, 0, 0, "R5");
    cycle(16'hFFFE, 1, 0, 0, "R5");
    // R4 ear input and fixed bits
    ear_i = 0;
    cycle(16'h00FE, 1, 0, 0, "R4");
    // R7 lock widens decode
    classic_lock_i = 1;
    cycle(16'h001E, 0, 1, 8'h15, "R7");
    cycle(16'h7F02, 1, 0, 0, "R7");
    classic_lock_i = 0;
    // simultaneous read and write
    cycle(16'h00FE, 1, 1, 8'h08, "R4");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a = 16'($urandom);
      if ($urandom % 2) a[7:5] = 3'b111;
      if ($urandom % 2) a[0] = 0;
      keys_ni = {8'($urandom), 32'($urandom)};
      ear_i = 1'($urandom);
      classic_lock_i = ($urandom % 4) == 0;
      cycle(a, 1'($urandom), 1'($urandom), 8'($urandom), "R5");
    end
    // R8 async reset clears outputs
    rst_ni = 0; #1;
    m_out = 0;
    chk_out("R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule